// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the register front end of an I/O interrupt controller. A simple bus has two word-wide locations. One is an 8-bit index select register. The other is a data window whose meaning depends on the current index. The window reaches several registers:

- a read-only version word;
- a 4-bit controller identifier, which can be written at one index and is read-only at a second;
- a table of 64-bit redirection entries, one per interrupt pin, each reached as two 32-bit halves at adjacent indices.

The block stores the table and drives every entry's fields to the delivery logic as parallel outputs. The delivery logic can set an entry's remote-IRR status bit through a per-pin input. A write to an entry's low half always clears that bit. Writes are mirrored to the delivery side by two registered one-cycle pulses:

- a low-half-write pulse, carrying the pin number;
- a mask-change pulse, carrying the pin number and the new mask value.

Servicing and delivery of interrupts are handled elsewhere.

Top module: `irw_window`

## Requirements
- R1: Bus offset 0x00 (decoded from `bus_addr[7:0]`) is the select register. A write stores `bus_wdata[7:0]` and drops the higher data bits. A read returns the stored value zero-extended. All read data appears on `bus_rdata` in the cycle after the read request.
- R2: At index 0x01 the window reads the version word: `NPINS-1` in bits 23:16 and the `VERSION` code in bits 7:0, with all other bits zero. Writes at this index change nothing.
- R3: At indices 0x00 and 0x02 the window reads the identifier in bits 27:24, with all other bits zero. A write at index 0x00 loads the identifier from `bus_wdata[27:24]`. A write at index 0x02 changes nothing.
- R4: For an index of 0x10 or above, the entry number is (index − 0x10) >> 1. An odd index reaches entry bits 63:32 and an even index reaches bits 31:0. Writing one half leaves the other half unchanged.
- R5: If the entry number is not below `NPINS`, a window write changes no state and raises no pulse, and a window read returns zero. Indices 0x03 to 0x0F also read zero and ignore writes.
- R6: A low-half write stores its data with entry bit 14 (remote IRR) forced to 0. A high-half write leaves bit 14 unchanged. A `rirr_set[p]` pulse sets bit 14 of entry p one cycle later. If a low-half write to the same entry happens in the same cycle, the write wins and the bit ends at 0.
- R7: When a low-half write changes entry bit 16 (mask), `mask_chg_vld` is high for one cycle in the cycle after the write, with `mask_chg_pin` set to the entry and `mask_chg_val` set to the new mask. A write that leaves the mask unchanged raises no pulse.
- R8: Every in-range low-half write raises `lo_wr_vld` for one cycle in the cycle after the write, with `lo_wr_pin` set to the entry. High-half writes do not raise it.
- R9: Reset clears the select register, the identifier and every entry, except that each entry's mask bit (bit 16) is set to 1.
- R10: Bus offsets other than 0x00 and 0x10 read zero and ignore writes. Address bits above bit 7 are not decoded, so for example 0x110 aliases the window.
- R11: Each pin's outputs show its stored entry, with the fields in these bits: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote IRR 14, trigger mode 15, mask 16, destination 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| rirr_set | input | NPINS | Per-pin remote-IRR set strobe from the delivery logic |
| pin_vector | output | NPINS*8 | Vector field of each entry |
| pin_dlv_mode | output | NPINS*3 | Delivery mode field of each entry |
| pin_dest_mode | output | NPINS | Destination mode bit of each entry |
| pin_polarity | output | NPINS | Polarity bit of each entry |
| pin_remote_irr | output | NPINS | Remote-IRR bit of each entry |
| pin_trigger | output | NPINS | Trigger mode bit of each entry |
| pin_mask | output | NPINS | Mask bit of each entry |
| pin_dest | output | NPINS*8 | Destination field of each entry |
| mask_chg_vld | output | 1 | Mask-change pulse |
| mask_chg_pin | output | PIN_W | Entry whose mask changed |
| mask_chg_val | output | 1 | New mask value |
| lo_wr_vld | output | 1 | Low-half write pulse |
| lo_wr_pin | output | PIN_W | Entry whose low half was written |

## Verification
The hardest case to reach from the ports is a low-half window write that lands in the same cycle as a `rirr_set` strobe for the same entry. Reaching it needs the select register aimed at that entry's even index beforehand, and the strobe must be driven in exactly the same cycle as the window write. The bench does this in a single access task that drives the write and the strobe together. It first proves that the strobe alone sets the bit and that a high-half write keeps it. Masks are then toggled and rewritten to the same value, to show that a pulse appears only on a real change. Out-of-range indices and aliased addresses are reached purely through the select register and upper address bits.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int WORD_W  = 32;
  localparam int ENT_W   = 64;
  localparam int IDX_W   = 8;
  localparam int ENTN_W  = 7;

  localparam logic [IDX_W-1:0] OFF_SELECT = 8'h00;
  localparam logic [IDX_W-1:0] OFF_WINDOW = 8'h10;

  localparam logic [IDX_W-1:0] IDX_ID      = 8'h00;
  localparam logic [IDX_W-1:0] IDX_VERSION = 8'h01;
  localparam logic [IDX_W-1:0] IDX_ARB     = 8'h02;
  localparam logic [IDX_W-1:0] IDX_TABLE   = 8'h10;

  localparam int F_VEC_LO   = 0;
  localparam int F_DLV_LO   = 8;
  localparam int F_DMODE    = 11;
  localparam int F_POL      = 13;
  localparam int F_RIRR     = 14;
  localparam int F_TRIG     = 15;
  localparam int F_MASK     = 16;
  localparam int F_DEST_LO  = 56;

  function automatic logic [WORD_W-1:0] version_word(input int npins,
                                                     input logic [7:0] ver);
    logic [7:0] top;
    top = 8'(npins - 1);
    return {8'h00, top, 8'h00, ver};
  endfunction

  function automatic logic [WORD_W-1:0] id_word(input logic [3:0] id);
    return {4'h0, id, 24'h000000};
  endfunction

  function automatic logic is_table_idx(input logic [IDX_W-1:0] idx);
    return idx >= IDX_TABLE;
  endfunction

  function automatic logic [ENTN_W-1:0] entry_of(input logic [IDX_W-1:0] idx);
    return ENTN_W'((idx - IDX_TABLE) >> 1);
  endfunction

  function automatic logic entry_ok(input logic [IDX_W-1:0] idx, input int npins);
    return is_table_idx(idx) && (int'(entry_of(idx)) < npins);
  endfunction

  function automatic logic [ENT_W-1:0] reset_entry();
    logic [ENT_W-1:0] e;
    e = '0;
    e[F_MASK] = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/irw_bus_decode.sv
module irw_bus_decode
  import irw_pkg::*;
(
  input  logic             req,
  input  logic             wr,
  input  logic [IDX_W-1:0] off,
  output logic             sel_wr,
  output logic             sel_rd,
  output logic             win_wr,
  output logic             win_rd
);
  logic sel_hit, win_hit;

  assign sel_hit = (off == OFF_SELECT);
  assign win_hit = (off == OFF_WINDOW);

  assign sel_wr = req &  wr & sel_hit;
  assign sel_rd = req & ~wr & sel_hit;
  assign win_wr = req &  wr & win_hit;
  assign win_rd = req & ~wr & win_hit;
endmodule

// File: rtl/irw_read_mux.sv
module irw_read_mux
  import irw_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic [IDX_W-1:0]       idx,
  input  logic [3:0]             id,
  input  logic [NPINS*ENT_W-1:0] ent_flat,
  output logic [WORD_W-1:0]      word
);
  logic [ENTN_W-1:0] ent_no;
  logic [WORD_W-1:0] tab_word;

  assign ent_no = entry_of(idx);

  always_comb begin
    tab_word = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (int'(ent_no) == p) begin
        tab_word = idx[0] ? ent_flat[p*ENT_W+WORD_W +: WORD_W]
                          : ent_flat[p*ENT_W +: WORD_W];
      end
    end
  end

  always_comb begin
    if (idx == IDX_ID || idx == IDX_ARB) begin
      word = id_word(id);
    end else if (idx == IDX_VERSION) begin
      word = version_word(NPINS, VERSION);
    end else if (entry_ok(idx, NPINS)) begin
      word = tab_word;
    end else begin
      word = '0;
    end
  end
endmodule

// File: rtl/irw_entry_table.sv
module irw_entry_table
  import irw_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int PIN_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_hi,
  input  logic [PIN_W-1:0]       wr_pin,
  input  logic [WORD_W-1:0]      wdata,
  input  logic [NPINS-1:0]       rirr_set,
  output logic [NPINS*ENT_W-1:0] ent_flat,
  output logic                   mask_chg_vld,
  output logic [PIN_W-1:0]       mask_chg_pin,
  output logic                   mask_chg_val,
  output logic                   lo_wr_vld,
  output logic [PIN_W-1:0]       lo_wr_pin
);
  logic [ENT_W-1:0] ent_q [NPINS];
  logic             lo_wr;
  logic             old_mask;
  logic             mask_flip;

  assign lo_wr     = wr_en & ~wr_hi;
  assign old_mask  = ent_q[wr_pin][F_MASK];
  assign mask_flip = lo_wr & (old_mask != wdata[F_MASK]);

  for (genvar p = 0; p < NPINS; p++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_pin == PIN_W'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[p] <= reset_entry();
      end else begin
        if (rirr_set[p]) ent_q[p][F_RIRR] <= 1'b1;
        if (hit) begin
          if (wr_hi) begin
            ent_q[p][ENT_W-1:WORD_W] <= wdata;
          end else begin
            ent_q[p][WORD_W-1:0] <= wdata;
            ent_q[p][F_RIRR]     <= 1'b0;
          end
        end
      end
    end

    assign ent_flat[p*ENT_W +: ENT_W] = ent_q[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_chg_vld <= 1'b0;
      mask_chg_pin <= '0;
      mask_chg_val <= 1'b0;
      lo_wr_vld    <= 1'b0;
      lo_wr_pin    <= '0;
    end else begin
      mask_chg_vld <= mask_flip;
      lo_wr_vld    <= lo_wr;
      if (mask_flip) begin
        mask_chg_pin <= wr_pin;
        mask_chg_val <= wdata[F_MASK];
      end
      if (lo_wr) lo_wr_pin <= wr_pin;
    end
  end
endmodule

// File: rtl/irw_window.sv
module irw_window
  import irw_pkg::*;
#(
  parameter int          NPINS   = 24,
  parameter int          ADDR_W  = 12,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int         PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   rirr_set,
  output logic [NPINS*8-1:0] pin_vector,
  output logic [NPINS*3-1:0] pin_dlv_mode,
  output logic [NPINS-1:0]   pin_dest_mode,
  output logic [NPINS-1:0]   pin_polarity,
  output logic [NPINS-1:0]   pin_remote_irr,
  output logic [NPINS-1:0]   pin_trigger,
  output logic [NPINS-1:0]   pin_mask,
  output logic [NPINS*8-1:0] pin_dest,
  output logic               mask_chg_vld,
  output logic [PIN_W-1:0]   mask_chg_pin,
  output logic               mask_chg_val,
  output logic               lo_wr_vld,
  output logic [PIN_W-1:0]   lo_wr_pin
);
  logic                   sel_wr, sel_rd, win_wr, win_rd;
  logic [IDX_W-1:0]       sel_q;
  logic [3:0]             id_q;
  logic [WORD_W-1:0]      win_word;
  logic [NPINS*ENT_W-1:0] ent_flat;
  logic                   tab_wr;
  logic [ENTN_W-1:0]      ent_no;
  logic                   unused_addr_hi;

  assign unused_addr_hi = ^bus_addr[ADDR_W-1:IDX_W];

  irw_bus_decode u_dec (
    .req    (bus_req),
    .wr     (bus_wr),
    .off    (bus_addr[IDX_W-1:0]),
    .sel_wr (sel_wr),
    .sel_rd (sel_rd),
    .win_wr (win_wr),
    .win_rd (win_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata[IDX_W-1:0];
      if (win_wr && sel_q == IDX_ID) id_q <= bus_wdata[27:24];
    end
  end

  assign ent_no = entry_of(sel_q);
  assign tab_wr = win_wr & entry_ok(sel_q, NPINS);

  irw_entry_table #(.NPINS(NPINS), .PIN_W(PIN_W)) u_tab (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (tab_wr),
    .wr_hi        (sel_q[0]),
    .wr_pin       (ent_no[PIN_W-1:0]),
    .wdata        (bus_wdata),
    .rirr_set     (rirr_set),
    .ent_flat     (ent_flat),
    .mask_chg_vld (mask_chg_vld),
    .mask_chg_pin (mask_chg_pin),
    .mask_chg_val (mask_chg_val),
    .lo_wr_vld    (lo_wr_vld),
    .lo_wr_pin    (lo_wr_pin)
  );

  irw_read_mux #(.NPINS(NPINS), .VERSION(VERSION)) u_rmux (
    .idx      (sel_q),
    .id       (id_q),
    .ent_flat (ent_flat),
    .word     (win_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (sel_rd) begin
      bus_rdata <= {{(WORD_W-IDX_W){1'b0}}, sel_q};
    end else if (win_rd) begin
      bus_rdata <= win_word;
    end else begin
      bus_rdata <= '0;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_fields
    logic [ENT_W-1:0] e;
    assign e = ent_flat[p*ENT_W +: ENT_W];
    assign pin_vector[p*8 +: 8]   = e[F_VEC_LO +: 8];
    assign pin_dlv_mode[p*3 +: 3] = e[F_DLV_LO +: 3];
    assign pin_dest_mode[p]       = e[F_DMODE];
    assign pin_polarity[p]        = e[F_POL];
    assign pin_remote_irr[p]      = e[F_RIRR];
    assign pin_trigger[p]         = e[F_TRIG];
    assign pin_mask[p]            = e[F_MASK];
    assign pin_dest[p*8 +: 8]     = e[F_DEST_LO +: 8];
  end
endmodule

// File: rtl/irw_checker.sv
module irw_checker #(
  parameter int NPINS = 24,
  parameter int PIN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_mask,
  input logic [NPINS-1:0] pin_remote_irr,
  input logic             mask_chg_vld,
  input logic [PIN_W-1:0] mask_chg_pin,
  input logic             mask_chg_val,
  input logic             lo_wr_vld,
  input logic [PIN_W-1:0] lo_wr_pin
);
  a_r7_pulse_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_vld |-> (pin_mask[mask_chg_pin] == mask_chg_val));

  a_r7_only_on_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_vld |-> (lo_wr_vld && lo_wr_pin == mask_chg_pin));

  a_r6_low_write_clears_rirr: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_vld |-> !pin_remote_irr[lo_wr_pin]);

  a_r5_pin_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_vld |-> (int'(lo_wr_pin) < NPINS));

  a_r8_mask_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_chg_vld && $past(mask_chg_vld)) |-> (lo_wr_pin != $past(lo_wr_pin) || $past(lo_wr_vld)));
endmodule

bind irw_window irw_checker #(.NPINS(NPINS), .PIN_W(PIN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pin_mask       (pin_mask),
  .pin_remote_irr (pin_remote_irr),
  .mask_chg_vld   (mask_chg_vld),
  .mask_chg_pin   (mask_chg_pin),
  .mask_chg_val   (mask_chg_val),
  .lo_wr_vld      (lo_wr_vld),
  .lo_wr_pin      (lo_wr_pin)
);

// File: tb/irw_window_tb_top.sv
module irw_window_tb_top;
  localparam int NP = 24;
  localparam int PW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_req = 1'b0, bus_wr = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   rirr_set = '0;
  logic [NP*8-1:0] pin_vector, pin_dest;
  logic [NP*3-1:0] pin_dlv_mode;
  logic [NP-1:0]   pin_dest_mode, pin_polarity, pin_remote_irr, pin_trigger, pin_mask;
  logic            mask_chg_vld, mask_chg_val, lo_wr_vld;
  logic [PW-1:0]   mask_chg_pin, lo_wr_pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irw_window dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rirr_set(rirr_set), .pin_vector(pin_vector), .pin_dlv_mode(pin_dlv_mode),
    .pin_dest_mode(pin_dest_mode), .pin_polarity(pin_polarity),
    .pin_remote_irr(pin_remote_irr), .pin_trigger(pin_trigger),
    .pin_mask(pin_mask), .pin_dest(pin_dest), .mask_chg_vld(mask_chg_vld),
    .mask_chg_pin(mask_chg_pin), .mask_chg_val(mask_chg_val),
    .lo_wr_vld(lo_wr_vld), .lo_wr_pin(lo_wr_pin)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] VER_EXP = ((NP - 1) << 16) | 32'h11;
  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 32'h0000_0001, 1'b0, 32'h0,          4'd1},  // R1 select version
    '{1'b0, 12'h000, 32'h0,         1'b1, 32'h0000_0001,  4'd1},  // R1 read select
    '{1'b0, 12'h010, 32'h0,         1'b1, VER_EXP,        4'd2},  // R2 version
    '{1'b1, 12'h010, 32'hFFFF_FFFF, 1'b0, 32'h0,          4'd2},  // R2 write ignored
    '{1'b0, 12'h010, 32'h0,         1'b1, VER_EXP,        4'd2},  // R2
    '{1'b1, 12'h000, 32'h0000_0000, 1'b0, 32'h0,          4'd3},
    '{1'b1, 12'h010, 32'hA500_0000, 1'b0, 32'h0,          4'd3},  // R3 id = 5
    '{1'b0, 12'h010, 32'h0,         1'b1, 32'h0500_0000,  4'd3},  // R3
    '{1'b1, 12'h000, 32'h0000_0002, 1'b0, 32'h0,          4'd3},
    '{1'b1, 12'h010, 32'h0F00_0000, 1'b0, 32'h0,          4'd3},  // R3 arb write ignored
    '{1'b0, 12'h010, 32'h0,         1'b1, 32'h0500_0000,  4'd3},  // R3
    '{1'b1, 12'h000, 32'h0000_0013, 1'b0, 32'h0,          4'd4},
    '{1'b1, 12'h010, 32'hDEAD_BEEF, 1'b0, 32'h0,          4'd4},  // R4 entry 1 high
    '{1'b0, 12'h010, 32'h0,         1'b1, 32'hDEAD_BEEF,  4'd4},  // R4
    '{1'b1, 12'h000, 32'h0000_0012, 1'b0, 32'h0,          4'd4},
    '{1'b0, 12'h010, 32'h0,         1'b1, 32'h0001_0000,  4'd4},  // R4 low half untouched
    '{1'b1, 12'h000, 32'h0000_01FF, 1'b0, 32'h0,          4'd1},
    '{1'b0, 12'h000, 32'h0,         1'b1, 32'h0000_00FF,  4'd1},  // R1 low 8 bits only
    '{1'b1, 12'h000, 32'h0000_0040, 1'b0, 32'h0,          4'd5},  // R5 entry 24
    '{1'b1, 12'h010, 32'h1234_5678, 1'b0, 32'h0,          4'd5},
    '{1'b0, 12'h010, 32'h0,         1'b1, 32'h0,          4'd5},  // R5 reads zero
    '{1'b0, 12'h004, 32'h0,         1'b1, 32'h0,          4'd10}  // R10 other offset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [11:0] addr, input logic [31:0] d,
                    input logic [NP-1:0] rs);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = d; rirr_set = rs;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; rirr_set = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check("R9 mask", 32'(pin_mask), 32'(24'hFFFFFF));
    check("R9 rirr", 32'(pin_remote_irr), 32'h0);
    op(1'b0, 12'h000, 32'h0, '0);
    check("R9 select", bus_rdata, 32'h0);
    op(1'b0, 12'h010, 32'h0, '0);
    check("R9 id", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VECS[i].wr, VECS[i].addr, VECS[i].wdata, '0);
      if (VECS[i].chk) check($sformatf("R%0d vec%0d", VECS[i].req, i), bus_rdata, VECS[i].exp);
      if (VECS[i].wr && VECS[i].addr == 12'h010 && i == 19)
        check("R5 no pulse", 32'(lo_wr_vld), 32'h0);
    end

    // R10 write to other offset ignored, high address bits alias
    op(1'b1, 12'h008, 32'h0000_0055, '0);
    op(1'b0, 12'h000, 32'h0, '0);
    check("R10 select kept", bus_rdata, 32'h0000_0040);
    op(1'b1, 12'h100, 32'h0000_0013, '0);
    op(1'b0, 12'h110, 32'h0, '0);
    check("R10 alias", bus_rdata, 32'hDEAD_BEEF);

    // R6 remote IRR set, kept by high write, cleared by low write
    op(1'b1, 12'h000, 32'h0000_0016, 24'h000008);
    check("R6 set", 32'(pin_remote_irr[3]), 32'h1);
    op(1'b1, 12'h000, 32'h0000_0017, '0);
    op(1'b1, 12'h010, 32'h1111_0000, '0);
    check("R6 hi keeps", 32'(pin_remote_irr[3]), 32'h1);
    check("R8 hi no pulse", 32'(lo_wr_vld), 32'h0);
    op(1'b1, 12'h000, 32'h0000_0016, '0);
    op(1'b1, 12'h010, 32'h0000_0022, 24'h000008);
    check("R6 write wins", 32'(pin_remote_irr[3]), 32'h0);
    check("R8 lo pulse", {31'h0, lo_wr_vld}, 32'h1);
    check("R8 lo pin", 32'(lo_wr_pin), 32'd3);
    check("R7 mask pulse", {31'h0, mask_chg_vld}, 32'h1);
    check("R7 mask pin", 32'(mask_chg_pin), 32'd3);
    check("R7 mask val", {31'h0, mask_chg_val}, 32'h0);
    op(1'b1, 12'h010, 32'h0000_0022, '0);
    check("R7 no change", {31'h0, mask_chg_vld}, 32'h0);
    check("R8 repeat pulse", {31'h0, lo_wr_vld}, 32'h1);
    op(1'b1, 12'h010, 32'h0001_0022, '0);
    check("R7 unmask->mask", {31'h0, mask_chg_vld}, 32'h1);
    check("R7 val one", {31'h0, mask_chg_val}, 32'h1);

    // R11 field positions on pin 5
    op(1'b1, 12'h000, 32'h0000_001A, '0);
    op(1'b1, 12'h010, 32'h0000_E9C7, '0);
    op(1'b1, 12'h000, 32'h0000_001B, '0);
    op(1'b1, 12'h010, 32'h7E00_0000, '0);
    check("R11 vector", 32'(pin_vector[5*8 +: 8]), 32'hC7);
    check("R11 dlv", 32'(pin_dlv_mode[5*3 +: 3]), 32'h1);
    check("R11 dmode", 32'(pin_dest_mode[5]), 32'h1);
    check("R11 pol", 32'(pin_polarity[5]), 32'h1);
    check("R11 trig", 32'(pin_trigger[5]), 32'h1);
    check("R11 mask", 32'(pin_mask[5]), 32'h0);
    check("R11 dest", 32'(pin_dest[5*8 +: 8]), 32'h7E);
    op(1'b1, 12'h000, 32'h0000_001A, '0);
    op(1'b0, 12'h010, 32'h0, '0);
    check("R6 bit14 cleared", bus_rdata, 32'h0000_A9C7);

    // R9 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R9 mask again", 32'(pin_mask), 32'(24'hFFFFFF));
    check("R9 vector clear", 32'(pin_vector[5*8 +: 8]), 32'h0);
    op(1'b0, 12'h000, 32'h0, '0);
    check("R9 select again", bus_rdata, 32'h0);
    op(1'b0, 12'h010, 32'h0, '0);
    check("R9 id again", bus_rdata, 32'h0);

    finish_run();
  end
endmodule